// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI master read and write a 32-bit register file over one chip-select. Each transaction is one fixed 64-bit frame, shifted most significant bit first in SPI mode 0: the slave samples MOSI on the rising SCLK edge and changes MISO on the falling edge. The frame starts with a direction bit (1 for write, 0 for read) and then a 15-bit register address.

In a write frame the 32-bit data word follows the address. An 8-bit gap comes after the data, and the write is committed during that gap. In a read frame the 8-bit gap comes straight after the address. The read request is issued when the gap starts, and the 32 data bits are shifted back on MISO once the gap ends. Both frame types finish with five padding bits, an acknowledge bit and a two-bit status code.

The SPI pins are brought into the system clock domain through synchronizers. The register file is reached through a request/done port: the request is held until the file answers or the gap runs out.

Top module: `spi_regport`

## Requirements
- R1: A frame whose bit 0 is 1 is a write. Bits 1-15 carry the address MSB first and bits 16-47 carry the data MSB first. The frame produces exactly one request with regWrite=1, regAddr equal to that address and regWdata equal to that word.
- R2: A frame whose bit 0 is 0 is a read. The 32-bit word the register file returns on regRdata appears on MISO in frame bits 24-55, MSB first.
- R3: Frame bit 61 carries the acknowledge and bits 62-63 carry the status, in the order status[1], status[0]. When an access completes normally, ack is 1 and status is 00. The status code 11 never appears.
- R4: A read request rises after frame bit 15 is sampled and before bit 16 is sampled. A write request rises after bit 47 is sampled and before bit 48 is sampled. The request stays high until regDone, falls on the clock after regDone, and is raised at most once per frame. A completion in the same cycle as the request (zero latency) counts as normal.
- R5: A completion that carries regErr gives ack 1 and status 01. For a read, every data bit of the frame is then 0, whatever regRdata held.
- R6: A request counts as timed out when no regDone has come by the falling edge that starts frame bit 24 (read) or frame bit 56 (write). The request is then withdrawn and the frame returns ack 0 and status 10. A read returns all-zero data, and no write completes.
- R7: Raising chip-select before the frame ends resets the bit counter and withdraws any pending request. A write frame cut off before bit 48 issues no request. The next frame is decoded from its own bit 0.
- R8: MISO is 0 while the slave is deselected and on every frame bit outside the read-data field and the acknowledge/status bits.
- R9: Clock edges after frame bit 63 are ignored: they raise no further request and MISO stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | SPI serial clock from the master |
| csNIn | input | 1 | Active-low chip-select |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| regReq | output | 1 | Register access request, held until done or withdrawn |
| regWrite | output | 1 | 1 for a write access, 0 for a read |
| regAddr | output | 15 | Register address |
| regWdata | output | 32 | Write data |
| regRdata | input | 32 | Read data, valid with regDone |
| regDone | input | 1 | Access completion strobe |
| regErr | input | 1 | Address not decoded, valid with regDone |

## Verification
The assertions check the request handshake on every cycle: the request falls after a completion, the address and data stay stable while it is pending, and no request survives past its gap. They also check that a deselect clears the counter, the request and MISO, that the status code never reads 11, and that the bit count never passes the frame length. Only the bench's frames can show the bit-exact frame content on MISO and when each request rises within the frame. The bench's frames also show the outcomes that depend on response latency (normal, decode error, timeout), that a cut-off frame commits nothing, and that extra clocks after the frame are ignored.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_NODEC   = 2'b01,
    ST_TIMEOUT = 2'b10
  } accStatus_t;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic clear;        // deselected: flush shift state, MISO low
    logic shiftIn;      // a rising SCLK sample
    logic captureAddr;  // last address bit arrives
    logic captureWdata; // last write data bit arrives
    logic latchRdata;   // read completion this cycle
    logic loadOut;      // first read data bit is driven
    logic shiftOut;     // further read data bits
    logic driveTail;    // ack / status bits
    logic tailBit;      // value for driveTail
    logic fallZero;     // any other falling edge
    logic outValid;     // read data may be shown
    logic useBus;       // take data straight from the bus this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int STAGES = 2,
  parameter int LANES = 3,
  parameter logic [LANES-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] rawIn,
  output logic [LANES-1:0] syncOut
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {STAGES{RESET_VAL[g]}};
      else       pipe <= {pipe[STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = pipe[STAGES-1];
  end

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  parameter int GAP_BITS = 8,
  parameter int PAD_BITS = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclkS,
  input  logic         csNS,
  input  logic         mosiS,
  input  logic         regDone,
  input  logic         regErr,
  output logic         regReq,
  output logic         regWrite,
  output ctrlStrobes_t strb
);

  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W + GAP_BITS + PAD_BITS + 3;
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] C_ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] C_RD_END    = CNT_W'(1 + ADDR_W + GAP_BITS);
  localparam logic [CNT_W-1:0] C_RD_DEND   = CNT_W'(1 + ADDR_W + GAP_BITS + DATA_W);
  localparam logic [CNT_W-1:0] C_WR_LAST   = CNT_W'(ADDR_W + DATA_W);
  localparam logic [CNT_W-1:0] C_WR_END    = CNT_W'(1 + ADDR_W + DATA_W + GAP_BITS);
  localparam logic [CNT_W-1:0] C_ACK       = CNT_W'(FRAME_LEN - 3);
  localparam logic [CNT_W-1:0] C_ST1       = CNT_W'(FRAME_LEN - 2);
  localparam logic [CNT_W-1:0] C_ST0       = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_FRAME     = CNT_W'(FRAME_LEN);

  logic [CNT_W-1:0] bitCnt;
  logic             dirQ, reqQ, ackQ, sclkPrev;
  accStatus_t       statusQ;

  logic csActive, riseEv, fallEv, doneNow, atDeadline, issueNow;
  logic [CNT_W-1:0] deadline;

  assign csActive   = !csNS;
  assign riseEv     = sclkS && !sclkPrev;
  assign fallEv     = !sclkS && sclkPrev;
  assign doneNow    = reqQ && regDone;
  assign deadline   = dirQ ? C_WR_END : C_RD_END;
  assign atDeadline = fallEv && (bitCnt == deadline);
  assign issueNow   = dirQ ? (bitCnt == C_WR_LAST) : (bitCnt == C_ADDR_LAST);

  always_comb begin
    strb = '0;
    strb.clear        = !csActive;
    strb.shiftIn      = csActive && riseEv && (bitCnt < C_FRAME);
    strb.captureAddr  = strb.shiftIn && (bitCnt == C_ADDR_LAST);
    strb.captureWdata = strb.shiftIn && dirQ && (bitCnt == C_WR_LAST);
    strb.latchRdata   = csActive && doneNow && !dirQ;
    strb.useBus       = doneNow;
    strb.outValid     = doneNow ? !regErr : (ackQ && (statusQ == ST_OK));
    strb.loadOut      = csActive && fallEv && !dirQ && (bitCnt == C_RD_END);
    strb.shiftOut     = csActive && fallEv && !dirQ &&
                        (bitCnt > C_RD_END) && (bitCnt < C_RD_DEND);
    strb.driveTail    = csActive && fallEv &&
                        ((bitCnt == C_ACK) || (bitCnt == C_ST1) || (bitCnt == C_ST0));
    if (bitCnt == C_ACK)      strb.tailBit = ackQ;
    else if (bitCnt == C_ST1) strb.tailBit = statusQ[1];
    else                      strb.tailBit = statusQ[0];
    strb.fallZero     = csActive && fallEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      dirQ     <= 1'b0;
      reqQ     <= 1'b0;
      ackQ     <= 1'b0;
      statusQ  <= ST_OK;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (!csActive) begin
        bitCnt  <= '0;
        dirQ    <= 1'b0;
        reqQ    <= 1'b0;
        ackQ    <= 1'b0;
        statusQ <= ST_OK;
      end else begin
        if (doneNow) begin
          reqQ    <= 1'b0;
          ackQ    <= 1'b1;
          statusQ <= regErr ? ST_NODEC : ST_OK;
        end else if (atDeadline && reqQ) begin
          reqQ    <= 1'b0;
          ackQ    <= 1'b0;
          statusQ <= ST_TIMEOUT;
        end
        if (strb.shiftIn) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == '0) dirQ <= mosiS;
          if (issueNow)     reqQ <= 1'b1;
        end
      end
    end
  end

  assign regReq   = reqQ;
  assign regWrite = dirQ;

  // R4: a completed request is dropped on the next clock
  a_r4_req_drop_after_done: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && regDone |=> !reqQ);

  // R7: deselect clears the counter and any pending request
  a_r7_idle_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == '0) && !reqQ);

  // R6: no request outlives its processing gap
  a_r6_no_req_past_gap: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt > deadline) |-> !reqQ);

  // R3: status code 11 never appears
  a_r3_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    statusQ != 2'b11);

  // R9: the bit counter never passes the frame length
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= C_FRAME);

endmodule

// File: rtl/spi_regport_dp.sv
module spi_regport_dp
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic              misoQ
);

  logic [DATA_W-1:0] inSr, inNext, outSr, rdataQ, outSrc;

  assign inNext = {inSr[DATA_W-2:0], mosiBit};
  assign outSrc = !strb.outValid ? '0 : (strb.useBus ? regRdata : rdataQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr   <= '0;
      outSr  <= '0;
      rdataQ <= '0;
      addrQ  <= '0;
      wdataQ <= '0;
      misoQ  <= 1'b0;
    end else if (strb.clear) begin
      inSr   <= '0;
      outSr  <= '0;
      rdataQ <= '0;
      misoQ  <= 1'b0;
    end else begin
      if (strb.shiftIn)      inSr   <= inNext;
      if (strb.captureAddr)  addrQ  <= inNext[ADDR_W-1:0];
      if (strb.captureWdata) wdataQ <= inNext;
      if (strb.latchRdata)   rdataQ <= regRdata;
      if (strb.loadOut) begin
        misoQ <= outSrc[DATA_W-1];
        outSr <= {outSrc[DATA_W-2:0], 1'b0};
      end else if (strb.shiftOut) begin
        misoQ <= outSr[DATA_W-1];
        outSr <= {outSr[DATA_W-2:0], 1'b0};
      end else if (strb.driveTail) begin
        misoQ <= strb.tailBit;
      end else if (strb.fallZero) begin
        misoQ <= 1'b0;
      end
    end
  end

  // R8: MISO goes low once deselected
  a_r8_miso_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !misoQ);

  // R5, R6: a read without valid data starts its field with a zero
  a_r5_masked_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadOut && !strb.outValid |=> !misoQ);

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  parameter int GAP_BITS = 8,
  parameter int PAD_BITS = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regDone,
  input  logic              regErr
);

  logic [2:0]   syncVec;
  ctrlStrobes_t strb;

  spi_regport_sync #(
    .STAGES(SYNC_STAGES), .LANES(3), .RESET_VAL(3'b010)
  ) uSync (
    .clk(clk), .rstN(rstN),
    .rawIn({sclkIn, csNIn, mosiIn}),
    .syncOut(syncVec)
  );

  spi_regport_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP_BITS(GAP_BITS), .PAD_BITS(PAD_BITS)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .sclkS(syncVec[2]), .csNS(syncVec[1]), .mosiS(syncVec[0]),
    .regDone(regDone), .regErr(regErr),
    .regReq(regReq), .regWrite(regWrite),
    .strb(strb)
  );

  spi_regport_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .mosiBit(syncVec[0]), .regRdata(regRdata),
    .addrQ(regAddr), .wdataQ(regWdata), .misoQ(misoOut)
  );

  // R4: address and data hold still while a request is pending
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    regReq && $past(regReq) |-> $stable(regAddr) && $stable(regWdata) && $stable(regWrite));

endmodule

// File: tb/spi_regport_test.sv
module spi_regport_test;

  localparam int H = 8;          // SCLK half period in clk cycles
  localparam int NEVER = 1000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b0, csNIn = 1'b1, mosiIn = 1'b0;
  logic        misoOut, regReq, regWrite;
  logic [14:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic        regDone, regErr;

  always #10 clk = ~clk;

  spi_regport uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csNIn(csNIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regDone(regDone), .regErr(regErr)
  );

  int checks = 0, failures = 0;
  logic [31:0] mem [256];
  int rspLat = 0;
  int reqCount = 0, commitCount = 0;
  logic [14:0] lastAddr;
  logic        lastWrite;
  logic [31:0] lastWdata;

  function automatic bit undecoded(logic [14:0] a);
    return a[14:8] != 7'd0;
  endfunction

  function automatic logic [63:0] expResp(logic dir, logic [31:0] rd, logic [1:0] st);
    logic ack;
    ack = (st != 2'b10);
    if (dir) return {61'b0, ack, st};
    return {24'b0, (st == 2'b00) ? rd : 32'b0, 5'b0, ack, st};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // register file model answering the request port
  initial begin : responder
    bit busy;
    int cnt;
    busy = 0; cnt = 0;
    regDone = 0; regErr = 0; regRdata = '0;
    forever begin
      @(negedge clk);
      regDone = 0; regErr = 0;
      if (busy && !regReq) busy = 0;
      else if (!busy && regReq && rstN) begin
        busy = 1; cnt = 0; reqCount++;
        lastAddr = regAddr; lastWrite = regWrite; lastWdata = regWdata;
      end
      if (busy) begin
        if (cnt >= rspLat) begin
          regDone = 1;
          regErr = undecoded(lastAddr);
          regRdata = regErr ? $urandom() : mem[lastAddr[7:0]];
          if (lastWrite && !regErr) begin
            mem[lastAddr[7:0]] = lastWdata;
            commitCount++;
          end
          busy = 0;
        end else cnt++;
      end
    end
  end

  task automatic runFrame(input logic dir, input logic [14:0] addr, input logic [31:0] wd,
                          input int nbits, output logic [63:0] rx,
                          output int firstReqBit, output bit extraMiso);
    logic [63:0] tx;
    int startCount;
    tx = dir ? {1'b1, addr, wd, 16'h0} : {1'b0, addr, 48'h0};
    startCount = reqCount;
    firstReqBit = -1; rx = '0; extraMiso = 0;
    @(negedge clk); csNIn = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      mosiIn = (k < 64) ? tx[63-k] : 1'b0;
      repeat (H) @(negedge clk);
      if (firstReqBit < 0 && reqCount != startCount) firstReqBit = k;
      if (k < 64) rx[63-k] = misoOut;
      else if (misoOut) extraMiso = 1;
      sclkIn = 1'b1;
      repeat (H) @(negedge clk);
      sclkIn = 1'b0;
    end
    repeat (H) @(negedge clk);
    csNIn = 1'b1; mosiIn = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic fullFrame(input logic dir, input logic [14:0] addr, input logic [31:0] wd,
                           input int lat, input string tag);
    logic [63:0] rx, ex;
    logic [1:0] st;
    logic [31:0] rd;
    int frb, c0, cm0;
    bit xm;
    rspLat = lat;
    rd = mem[addr[7:0]];
    st = (lat > 170) ? 2'b10 : (undecoded(addr) ? 2'b01 : 2'b00);
    c0 = reqCount; cm0 = commitCount;
    runFrame(dir, addr, wd, 64, rx, frb, xm);
    ex = expResp(dir, rd, st);
    check(rx === ex, {tag, " R2 R3 R5 R6 R8 frame response"}, rx, ex);
    check(reqCount == c0 + 1, {tag, " R4 one request per frame"}, 64'(reqCount - c0), 64'd1);
    check(frb == (dir ? 48 : 16), {tag, " R4 request bit position"}, 64'(frb), dir ? 64'd48 : 64'd16);
    check(lastAddr == addr && lastWrite == dir, {tag, " R1 request address/direction"},
          {48'b0, lastWrite, lastAddr}, {48'b0, dir, addr});
    if (dir) begin
      check(lastWdata == wd, {tag, " R1 write data"}, 64'(lastWdata), 64'(wd));
      check(commitCount == cm0 + ((st == 2'b00) ? 1 : 0), {tag, " R6 write commit count"},
            64'(commitCount - cm0), (st == 2'b00) ? 64'd1 : 64'd0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [63:0] rx;
    int frb, c0, cm0;
    bit xm;
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h01030507) ^ 32'h5A5AC3C3;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // reset state (R8, R4)
    check(misoOut == 1'b0, "R8 reset MISO", 64'(misoOut), 64'd0);
    check(regReq == 1'b0, "R4 reset request", 64'(regReq), 64'd0);

    // directed frames
    fullFrame(1'b1, 15'h0012, 32'hCAFEF00D, 5, "R1 write ok");
    fullFrame(1'b0, 15'h0012, 32'h0, 40, "R2 readback");
    fullFrame(1'b0, 15'h0044, 32'h0, 0, "R4 zero latency read");
    fullFrame(1'b1, 15'h0045, 32'h80000001, 0, "R4 zero latency write");
    fullFrame(1'b0, 15'h7F00, 32'h0, 3, "R5 undecoded read");
    fullFrame(1'b1, 15'h0300, 32'h12345678, 3, "R5 undecoded write");
    fullFrame(1'b0, 15'h0020, 32'h0, NEVER, "R6 read timeout");
    fullFrame(1'b1, 15'h0021, 32'hFFFFFFFF, 250, "R6 write timeout");
    fullFrame(1'b0, 15'h0021, 32'h0, 10, "R6 timed-out write left cell");

    // abort before the write gap: no request (R7)
    rspLat = 5; c0 = reqCount;
    runFrame(1'b1, 15'h0030, 32'hAAAA5555, 30, rx, frb, xm);
    check(reqCount == c0, "R7 aborted write issues no request", 64'(reqCount - c0), 64'd0);
    check(misoOut == 1'b0, "R8 MISO low after abort", 64'(misoOut), 64'd0);
    fullFrame(1'b0, 15'h0030, 32'h0, 7, "R7 frame after abort");

    // abort inside the write gap with a pending request (R7)
    rspLat = NEVER; c0 = reqCount; cm0 = commitCount;
    runFrame(1'b1, 15'h0031, 32'h0F0F0F0F, 52, rx, frb, xm);
    check(reqCount == c0 + 1, "R7 gap abort had raised a request", 64'(reqCount - c0), 64'd1);
    check(regReq == 1'b0, "R7 pending request withdrawn", 64'(regReq), 64'd0);
    check(commitCount == cm0, "R7 no commit after abort", 64'(commitCount - cm0), 64'd0);

    // extra clocks beyond the frame (R9)
    rspLat = 4; c0 = reqCount;
    runFrame(1'b0, 15'h0031, 32'h0, 70, rx, frb, xm);
    check(reqCount == c0 + 1, "R9 no extra request", 64'(reqCount - c0), 64'd1);
    check(xm == 1'b0, "R9 MISO low after frame", 64'(xm), 64'd0);
    check(rx === expResp(1'b0, mem[8'h31], 2'b00), "R2 read within long frame",
          rx, expResp(1'b0, mem[8'h31], 2'b00));

    // constrained random frames
    for (int n = 0; n < 36; n++) begin
      logic d;
      logic [14:0] a;
      logic [31:0] w;
      int lat;
      d = 1'($urandom_range(0, 1));
      a = ($urandom_range(0, 4) == 0) ? {7'($urandom_range(1, 127)), 8'($urandom())}
                                      : {7'd0, 8'($urandom())};
      w = $urandom();
      lat = ($urandom_range(0, 4) == 0) ? int'($urandom_range(180, 400)) : int'($urandom_range(0, 90));
      fullFrame(d, a, w, lat, "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule